// File: doc/BRIEF.md
# Cache Control Operation Sequencer

This block carries out one cache management operation at a time against the data-cache line it targets. An operation arrives as an opcode and an address over a valid/ready handshake. The block looks up the current state of the line. The cache has three states: Invalid, Exclusive and Modified, with no Shared state. From that state the block chooses the single bus transaction the operation needs, if any, and holds the request until the bus acknowledges it. It then writes the resulting line state back through an update port. Prefetch touches that miss leave their line address in a one-entry touch-load buffer.

A configuration input controls optional address-only broadcasts for the invalidate, flush and store operations. These broadcasts expect no snoop response. Of all the transactions other bus masters issue, the block honours only a cache block kill. A kill invalidates the matching data line and any touch-load entry for that line. If the kill hits the line of the operation in flight, that operation continues as if the line had been Invalid.

Top module: `cache_op_seq`

## Requirements
- R1: An operation is accepted on a clock edge where `op_valid_i` and `op_ready_o` are both high. `op_ready_o` then stays low until that operation completes.
- R2: Opcode 0 (sync) issues no bus operation and changes no line state. It completes only in a cycle where `mq_idle_i` is high.
- R3: Opcode 1 (instruction-block invalidate) issues no bus operation and raises `upd_valid_o` with `upd_icache_o`=1 and state 0. Opcode 2 (data-block invalidate) ends in state 0 (Invalid).
- R4: Opcode 3 (flush) on state 2 (Modified) issues bus op 4 (write-with-kill). On any state it ends in state 0.
- R5: Opcode 4 (store) on state 2 issues bus op 3 (write) and ends in state 1 (Exclusive). On states 0 and 1 it leaves the state unchanged.
- R6: Opcode 5 (zero) issues bus op 5 (kill) on any state and ends in state 2.
- R7: Opcode 6 (touch) on state 0 issues bus op 1 (read), and opcode 7 (touch for store) issues bus op 2 (read-with-intent-to-modify). In both cases the line address is then held in the touch buffer (`touch_vld_o`, `touch_addr_o` aligned to the line). Neither opcode changes the line state. On state 1 or 2 neither issues a bus operation.
- R8: With `bcast_en_i` high, opcode 2 issues bus op 5 (kill). Opcode 3 on state 0 or 1 issues bus op 6 (flush). Opcode 4 on state 0 or 1 issues bus op 7 (clean). With `bcast_en_i` low, these cases issue no bus op.
- R9: `snp_kill_i` raises `inv_valid_o` for `snp_addr_i`. It clears the touch buffer when the line matches, unless a touch fill lands in the same cycle. If it matches the line of the operation in flight, that operation continues with state 0.
- R10: `bus_req_o` stays high with stable `bus_op_o` and `bus_addr_o` until the cycle in which `bus_ack_i` is high.
- R11: After reset `op_ready_o` is high, and `bus_req_o`, `upd_valid_o` and `touch_vld_o` are low.
- R12: `upd_valid_o` pulses for one cycle at completion only when the resulting state differs from the current one (always for opcode 1). The pulse carries the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| bcast_en_i | input | 1 | enable address-only broadcasts |
| op_valid_i | input | 1 | operation valid |
| op_ready_o | output | 1 | ready for an operation |
| op_code_i | input | 3 | opcode |
| op_addr_i | input | AW | operation address |
| mq_idle_i | input | 1 | memory queues drained |
| lk_addr_o | output | AW | lookup address |
| lk_state_i | input | 2 | looked-up line state |
| upd_valid_o | output | 1 | state update strobe |
| upd_icache_o | output | 1 | update targets the instruction cache |
| upd_addr_o | output | AW | update address |
| upd_state_o | output | 2 | new line state |
| bus_req_o | output | 1 | bus request |
| bus_op_o | output | 3 | bus operation code |
| bus_addr_o | output | AW | bus address |
| bus_ack_i | input | 1 | bus acknowledge |
| snp_kill_i | input | 1 | snooped kill from another master |
| snp_addr_i | input | AW | snooped address |
| inv_valid_o | output | 1 | snoop invalidate strobe |
| inv_addr_o | output | AW | snoop invalidate address |
| touch_vld_o | output | 1 | touch buffer holds a line |
| touch_addr_o | output | AW | touch buffer line address |

## Verification
The bench builds the block with AW=32 and OFF=5, so each line is 32 bytes. It gives every line its own slot, indexed by address bits 8:5, in a small state array. That is enough to put each opcode against each line state and to aim kills at the line in flight or the buffered touch line. Operation addresses carry a nonzero offset and high bits, so that line-tag matching and the aligned touch address are both exercised. The bus acknowledge latency varies from zero to several cycles, which keeps a request open long enough for a kill to land during the transfer.

// File: rtl/cop_pkg.sv
package cop_pkg;
  typedef enum logic [2:0] {
    OP_SYNC, OP_ICBI, OP_DCBI, OP_DCBF, OP_DCBST, OP_DCBZ, OP_DCBT, OP_DCBTST
  } op_e;

  typedef enum logic [1:0] {
    LS_INV = 2'd0, LS_EXC = 2'd1, LS_MOD = 2'd2
  } lst_e;

  typedef enum logic [2:0] {
    BO_NONE, BO_READ, BO_RWITM, BO_WRITE, BO_WWK, BO_KILL, BO_FLUSH, BO_CLEAN
  } bop_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_EXEC, PH_BUS
  } ph_e;
endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_pkg::*;
(
  input  op_e  op_i,
  input  lst_e st_i,
  input  logic bcast_i,
  output bop_e bop_o,
  output lst_e nxt_o
);
  logic is_mod, is_inv;
  assign is_mod = (st_i == LS_MOD);
  assign is_inv = (st_i == LS_INV);

  always_comb begin
    bop_o = BO_NONE;
    nxt_o = st_i;
    case (op_i)
      OP_SYNC: ;
      OP_ICBI: nxt_o = LS_INV;
      OP_DCBI: begin
        nxt_o = LS_INV;
        if (bcast_i) bop_o = BO_KILL;
      end
      OP_DCBF: begin
        nxt_o = LS_INV;
        if (is_mod)       bop_o = BO_WWK;
        else if (bcast_i) bop_o = BO_FLUSH;
      end
      OP_DCBST: begin
        if (is_mod) begin
          bop_o = BO_WRITE;
          nxt_o = LS_EXC;
        end else if (bcast_i) begin
          bop_o = BO_CLEAN;
        end
      end
      OP_DCBZ: begin
        bop_o = BO_KILL;
        nxt_o = LS_MOD;
      end
      OP_DCBT:   if (is_inv) bop_o = BO_READ;
      OP_DCBTST: if (is_inv) bop_o = BO_RWITM;
      default: ;
    endcase
  end
endmodule

// File: rtl/cop_line_cmp.sv
module cop_line_cmp #(
  parameter int TW = 27
) (
  input  logic [TW-1:0] a_i,
  input  logic [TW-1:0] b_i,
  output logic          eq_o
);
  assign eq_o = (a_i == b_i);
endmodule

// File: rtl/cop_touch_buf.sv
module cop_touch_buf #(
  parameter int TW = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [TW-1:0] set_tag_i,
  input  logic          kill_i,
  input  logic [TW-1:0] kill_tag_i,
  output logic          vld_o,
  output logic [TW-1:0] tag_o
);
  logic hit;

  cop_line_cmp #(.TW(TW)) u_cmp (
    .a_i  (tag_o),
    .b_i  (kill_tag_i),
    .eq_o (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      tag_o <= '0;
    end else if (set_i) begin
      vld_o <= 1'b1;
      tag_o <= set_tag_i;
    end else if (kill_i && hit) begin
      vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cache_op_seq.sv
module cache_op_seq
  import cop_pkg::*;
#(
  parameter int AW  = 32,
  parameter int OFF = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bcast_en_i,
  input  logic          op_valid_i,
  output logic          op_ready_o,
  input  logic [2:0]    op_code_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic          mq_idle_i,
  output logic [AW-1:0] lk_addr_o,
  input  logic [1:0]    lk_state_i,
  output logic          upd_valid_o,
  output logic          upd_icache_o,
  output logic [AW-1:0] upd_addr_o,
  output logic [1:0]    upd_state_o,
  output logic          bus_req_o,
  output logic [2:0]    bus_op_o,
  output logic [AW-1:0] bus_addr_o,
  input  logic          bus_ack_i,
  input  logic          snp_kill_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic          inv_valid_o,
  output logic [AW-1:0] inv_addr_o,
  output logic          touch_vld_o,
  output logic [AW-1:0] touch_addr_o
);
  localparam int TW = AW - OFF;

  ph_e           ph_q;
  op_e           op_q;
  lst_e          st_q;
  bop_e          bop_q;
  logic [AW-1:0] addr_q;

  bop_e          bop_w;
  lst_e          nxt_w;
  logic          hit_new, hit_cur, done, accept, touch_set;
  logic [TW-1:0] touch_tag;

  cop_decode u_dec (
    .op_i    (op_q),
    .st_i    (st_q),
    .bcast_i (bcast_en_i),
    .bop_o   (bop_w),
    .nxt_o   (nxt_w)
  );

  cop_line_cmp #(.TW(TW)) u_cmp_new (
    .a_i  (op_addr_i[AW-1:OFF]),
    .b_i  (snp_addr_i[AW-1:OFF]),
    .eq_o (hit_new)
  );

  cop_line_cmp #(.TW(TW)) u_cmp_cur (
    .a_i  (addr_q[AW-1:OFF]),
    .b_i  (snp_addr_i[AW-1:OFF]),
    .eq_o (hit_cur)
  );

  assign accept = op_valid_i && op_ready_o;

  always_comb begin
    done = 1'b0;
    case (ph_q)
      PH_EXEC: done = (op_q == OP_SYNC) ? mq_idle_i : (bop_w == BO_NONE);
      PH_BUS:  done = bus_ack_i;
      default: done = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      op_q   <= OP_SYNC;
      st_q   <= LS_INV;
      bop_q  <= BO_NONE;
      addr_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (accept) begin
          op_q   <= op_e'(op_code_i);
          addr_q <= op_addr_i;
          st_q   <= (snp_kill_i && hit_new) ? LS_INV : lst_e'(lk_state_i);
          ph_q   <= PH_EXEC;
        end
        PH_EXEC: begin
          if (done) begin
            ph_q <= PH_IDLE;
          end else if (op_q != OP_SYNC) begin
            bop_q <= bop_w;
            ph_q  <= PH_BUS;
          end
        end
        PH_BUS: if (done) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
      // kill on the in-flight line: continue as if Invalid
      if (ph_q != PH_IDLE && snp_kill_i && hit_cur) st_q <= LS_INV;
    end
  end

  assign op_ready_o   = (ph_q == PH_IDLE);
  assign lk_addr_o    = op_addr_i;

  assign upd_valid_o  = done && ((op_q == OP_ICBI) || (nxt_w != st_q));
  assign upd_icache_o = (op_q == OP_ICBI);
  assign upd_addr_o   = addr_q;
  assign upd_state_o  = nxt_w;

  assign bus_req_o    = (ph_q == PH_BUS);
  assign bus_op_o     = bop_q;
  assign bus_addr_o   = addr_q;

  assign inv_valid_o  = snp_kill_i;
  assign inv_addr_o   = snp_addr_i;

  assign touch_set = (ph_q == PH_BUS) && bus_ack_i &&
                     ((bop_q == BO_READ) || (bop_q == BO_RWITM));

  cop_touch_buf #(.TW(TW)) u_touch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (touch_set),
    .set_tag_i  (addr_q[AW-1:OFF]),
    .kill_i     (snp_kill_i),
    .kill_tag_i (snp_addr_i[AW-1:OFF]),
    .vld_o      (touch_vld_o),
    .tag_o      (touch_tag)
  );

  assign touch_addr_o = {touch_tag, {OFF{1'b0}}};
endmodule

// File: rtl/cop_chk.sv
module cop_chk
  import cop_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_valid_i,
  input logic          op_ready_o,
  input logic          bus_req_o,
  input logic          bus_ack_i,
  input logic [2:0]    bus_op_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          upd_valid_o,
  input logic [1:0]    upd_state_o,
  input ph_e           ph_i,
  input op_e           op_i
);
  a_r1_one_at_a_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_ready_o |=> !op_ready_o);

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_op_o) && $stable(bus_addr_o));

  a_r2_sync_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i != PH_IDLE) && (op_i == OP_SYNC) |-> !bus_req_o && !upd_valid_o);

  a_r3_icbi_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i != PH_IDLE) && (op_i == OP_ICBI) |-> !bus_req_o);

  a_r4_dcbf_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && (op_i == OP_DCBF) |-> (bus_op_o == BO_WWK) || (bus_op_o == BO_FLUSH));

  a_r5_dcbst_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && (op_i == OP_DCBST) |-> (bus_op_o == BO_WRITE) || (bus_op_o == BO_CLEAN));

  a_r6_dcbz_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o && (op_i == OP_DCBZ) |-> upd_state_o == LS_MOD);

  a_r7_touch_no_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DCBT || op_i == OP_DCBTST) && (ph_i != PH_IDLE) |-> !upd_valid_o);
endmodule

bind cache_op_seq cop_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .op_ready_o  (op_ready_o),
  .bus_req_o   (bus_req_o),
  .bus_ack_i   (bus_ack_i),
  .bus_op_o    (bus_op_o),
  .bus_addr_o  (bus_addr_o),
  .upd_valid_o (upd_valid_o),
  .upd_state_o (upd_state_o),
  .ph_i        (ph_q),
  .op_i        (op_q)
);

// File: tb/cache_op_seq_bench.sv
`timescale 1ns/1ps
module cache_op_seq_bench;
  localparam int AW = 32;
  localparam int OFF = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic          bcast_en_i = 1'b0, op_valid_i = 1'b0, mq_idle_i = 1'b1;
  logic          bus_ack_i = 1'b0, snp_kill_i = 1'b0;
  logic [2:0]    op_code_i = '0;
  logic [AW-1:0] op_addr_i = '0, snp_addr_i = '0;
  logic [1:0]    lk_state_i;
  logic          op_ready_o, upd_valid_o, upd_icache_o, bus_req_o, inv_valid_o, touch_vld_o;
  logic [AW-1:0] lk_addr_o, upd_addr_o, bus_addr_o, inv_addr_o, touch_addr_o;
  logic [1:0]    upd_state_o;
  logic [2:0]    bus_op_o;

  cache_op_seq #(.AW(AW), .OFF(OFF)) u_cache_op_seq (.*);

  logic [1:0] mem [16];
  assign lk_state_i = mem[lk_addr_o[8:5]];

  int errs = 0, chks = 0;
  bit fin = 0;
  int ack_lat = 1, seen_cnt = 0, seen_bop = 0;
  bit pre_we = 0;
  int pre_idx = 0, pre_val = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_bus(int op, int st, bit bc);
    if (op == 2) return bc ? 5 : 0;
    if (op == 3) return (st == 2) ? 4 : (bc ? 6 : 0);
    if (op == 4) return (st == 2) ? 3 : (bc ? 7 : 0);
    if (op == 5) return 5;
    if (op == 6) return (st == 0) ? 1 : 0;
    if (op == 7) return (st == 0) ? 2 : 0;
    return 0;
  endfunction

  function automatic int exp_nxt(int op, int st);
    if (op >= 1 && op <= 3) return 0;
    if (op == 4) return (st == 2) ? 1 : st;
    if (op == 5) return 2;
    return st;
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // behavioural reference model
  int m_ph = 0, m_op = 0, m_st = 0, m_bop = 0;
  logic [AW-1:0] m_addr = '0;
  bit m_tv = 0;
  logic [AW-OFF-1:0] m_tt = '0;

  function automatic bit m_done();
    if (m_ph == 1) return (m_op == 0) ? bit'(mq_idle_i) : (exp_bus(m_op, m_st, bcast_en_i) == 0);
    if (m_ph == 2) return bus_ack_i;
    return 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    int ph0;
    bit d, tset;
    int bx;
    if (!rst_ni) begin
      m_ph = 0; m_tv = 0; m_op = 0; m_st = 0; m_bop = 0;
    end else begin
      ph0 = m_ph; d = m_done(); tset = 0; bx = exp_bus(m_op, m_st, bcast_en_i);
      if (ph0 == 0 && op_valid_i) begin
        m_op = int'(op_code_i); m_addr = op_addr_i;
        m_st = (snp_kill_i && snp_addr_i[AW-1:OFF] == op_addr_i[AW-1:OFF]) ? 0 : int'(lk_state_i);
        m_ph = 1;
      end else if (ph0 == 1) begin
        if (d) m_ph = 0;
        else if (m_op != 0) begin m_bop = bx; m_ph = 2; end
      end else if (ph0 == 2 && d) begin
        if (m_bop == 1 || m_bop == 2) begin m_tv = 1; m_tt = m_addr[AW-1:OFF]; tset = 1; end
        m_ph = 0;
      end
      if (snp_kill_i) begin
        if (ph0 != 0 && snp_addr_i[AW-1:OFF] == m_addr[AW-1:OFF]) m_st = 0;
        if (!tset && m_tv && snp_addr_i[AW-1:OFF] == m_tt) m_tv = 0;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk_i) begin
    bit d, eu;
    int nx;
    if (rst_ni && !fin) begin
      d = m_done(); nx = exp_nxt(m_op, m_st);
      eu = d && (m_op == 1 || nx != m_st);
      chk(op_ready_o == (m_ph == 0), "R1 ready", op_ready_o, m_ph == 0);
      chk(bus_req_o == (m_ph == 2), "R10 req", bus_req_o, m_ph == 2);
      if (m_ph == 2) begin
        chk(int'(bus_op_o) == m_bop, req_of(m_op), bus_op_o, m_bop);
        chk(bus_addr_o == m_addr, "R10 addr", bus_addr_o, m_addr);
      end
      chk(upd_valid_o == eu, {"R12 ", req_of(m_op)}, upd_valid_o, eu);
      if (eu) begin
        chk(int'(upd_state_o) == nx, req_of(m_op), upd_state_o, nx);
        chk(upd_addr_o == m_addr, "R12 addr", upd_addr_o, m_addr);
        chk(upd_icache_o == (m_op == 1), "R3 icache", upd_icache_o, m_op == 1);
      end
      chk(touch_vld_o == m_tv, "R7 touch", touch_vld_o, m_tv);
      if (m_tv) chk(touch_addr_o == {m_tt, 5'b0}, "R7 touch addr", touch_addr_o, {m_tt, 5'b0});
      chk(inv_valid_o == snp_kill_i, "R9 inv", inv_valid_o, snp_kill_i);
    end
  end

  // environment: line state array and bus observation
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pre_we) mem[pre_idx] = 2'(pre_val);
      if (upd_valid_o && !upd_icache_o) mem[upd_addr_o[8:5]] = upd_state_o;
      if (inv_valid_o) mem[inv_addr_o[8:5]] = 2'd0;
      if (bus_req_o && bus_ack_i) begin seen_bop = int'(bus_op_o); seen_cnt++; end
    end else begin
      for (int i = 0; i < 16; i++) mem[i] = 2'd0;
    end
  end

  always @(posedge clk_i) begin
    int wc;
    #1;
    bus_ack_i = 1'b0;
    if (bus_req_o) begin
      if (wc >= ack_lat) begin bus_ack_i = 1'b1; wc = 0; end
      else wc++;
    end else wc = 0;
  end

  function automatic logic [AW-1:0] addr_of(int idx);
    return 32'h4000_0000 | AW'(idx << 5) | 32'h4;
  endfunction

  task automatic preload(int idx, int v);
    pre_idx = idx; pre_val = v; pre_we = 1;
    @(negedge clk_i); #1;
    pre_we = 0;
  endtask

  task automatic wait_idle();
    while (!op_ready_o) begin @(posedge clk_i); #1; end
  endtask

  task automatic do_op(int op, int idx, int ebop, int efin, string req);
    int c0;
    c0 = seen_cnt;
    @(posedge clk_i); #1;
    op_valid_i = 1'b1; op_code_i = 3'(op); op_addr_i = addr_of(idx);
    wait_idle();
    @(posedge clk_i); #1;
    op_valid_i = 1'b0;
    wait_idle();
    @(negedge clk_i); #1;
    if (ebop == 0) chk(seen_cnt == c0, req, seen_cnt - c0, 0);
    else begin
      chk(seen_cnt == c0 + 1, req, seen_cnt - c0, 1);
      chk(seen_bop == ebop, req, seen_bop, ebop);
    end
    chk(int'(mem[idx]) == efin, req, mem[idx], efin);
  endtask

  task automatic snoop(int idx);
    @(posedge clk_i); #1;
    snp_kill_i = 1'b1; snp_addr_i = addr_of(idx) ^ 32'h8;
    @(posedge clk_i); #1;
    snp_kill_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(op_ready_o == 1'b1, "R11 ready", op_ready_o, 1);
    chk(bus_req_o == 1'b0, "R11 req", bus_req_o, 0);
    chk(upd_valid_o == 1'b0, "R11 upd", upd_valid_o, 0);
    chk(touch_vld_o == 1'b0, "R11 touch", touch_vld_o, 0);
    rst_ni = 1'b1;
    preload(1, 2); preload(2, 1); preload(4, 2); preload(5, 2);
    preload(8, 1); preload(9, 1); preload(10, 1); preload(11, 2);
    preload(12, 2); preload(13, 2);

    ack_lat = 1; bcast_en_i = 1'b0;
    do_op(4, 1, 3, 1, "R5 store M");
    do_op(4, 2, 0, 1, "R5 store E");
    do_op(3, 1, 0, 0, "R4 flush E");
    ack_lat = 0;
    do_op(3, 4, 4, 0, "R4 flush M");
    do_op(2, 2, 0, 0, "R3 dinv");
    do_op(1, 5, 0, 2, "R3 iinv");
    ack_lat = 3;
    do_op(5, 3, 5, 2, "R6 zero I");
    do_op(5, 3, 5, 2, "R6 zero M");
    do_op(6, 6, 1, 0, "R7 touch I");
    chk(touch_vld_o == 1'b1, "R7 buf vld", touch_vld_o, 1);
    chk(touch_addr_o == (addr_of(6) & ~32'h1f), "R7 buf addr", touch_addr_o, addr_of(6) & ~32'h1f);
    do_op(6, 3, 0, 2, "R7 touch M");
    chk(touch_addr_o == (addr_of(6) & ~32'h1f), "R7 buf kept", touch_addr_o, addr_of(6) & ~32'h1f);
    ack_lat = 2;
    do_op(7, 7, 2, 0, "R7 touchst I");
    chk(touch_addr_o == (addr_of(7) & ~32'h1f), "R7 buf addr2", touch_addr_o, addr_of(7) & ~32'h1f);

    // sync waits for drained queues
    mq_idle_i = 1'b0;
    @(posedge clk_i); #1;
    op_valid_i = 1'b1; op_code_i = 3'd0; op_addr_i = addr_of(0);
    @(posedge clk_i); #1;
    op_valid_i = 1'b0;
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    chk(op_ready_o == 1'b0, "R2 sync waits", op_ready_o, 0);
    @(posedge clk_i); #1;
    mq_idle_i = 1'b1;
    @(negedge clk_i);
    chk(op_ready_o == 1'b0, "R2 done cycle", op_ready_o, 0);
    @(negedge clk_i);
    chk(op_ready_o == 1'b1, "R2 sync done", op_ready_o, 1);

    bcast_en_i = 1'b1; ack_lat = 1;
    do_op(2, 8, 5, 0, "R8 dinv bcast");
    do_op(3, 9, 6, 0, "R8 flush bcast");
    do_op(4, 10, 7, 1, "R8 store bcast");
    do_op(4, 11, 3, 1, "R8 store M bcast");
    do_op(3, 2, 6, 0, "R8 flush I bcast");
    bcast_en_i = 1'b0;

    snoop(12);
    @(negedge clk_i); #1;
    chk(int'(mem[12]) == 0, "R9 snoop line", mem[12], 0);
    snoop(7);
    @(negedge clk_i); #1;
    chk(touch_vld_o == 1'b0, "R9 touch cleared", touch_vld_o, 0);

    // kill lands during an open transfer
    ack_lat = 4;
    @(posedge clk_i); #1;
    op_valid_i = 1'b1; op_code_i = 3'd4; op_addr_i = addr_of(13);
    @(posedge clk_i); #1;
    op_valid_i = 1'b0;
    while (!bus_req_o) begin @(posedge clk_i); #1; end
    snp_kill_i = 1'b1; snp_addr_i = addr_of(13);
    @(posedge clk_i); #1;
    snp_kill_i = 1'b0;
    wait_idle();
    @(negedge clk_i); #1;
    chk(int'(mem[13]) == 0, "R9 kill in flight", mem[13], 0);

    // back-to-back with zero latency
    ack_lat = 0;
    do_op(5, 14, 5, 2, "R6 zero fast");
    do_op(3, 14, 4, 0, "R4 flush fast");

    repeat (3) @(posedge clk_i);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!fin) begin
      fin = 1;
      chks++; errs++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule